// File: doc/BRIEF.md
# Region-Based Memory Access Checker

This block sits beside a processor's memory port and judges each access against a small table of physical-address regions. Every request carries an address, an access kind (data read, data write or instruction fetch) and a privilege flag. The block answers one cycle later with an allow or deny verdict. A denied access raises a one-cycle fault pulse. The first fault is recorded in a status capture that holds until privileged software clears it.

Each region has a base address and a size exponent. A region of size 2^e is always aligned to that size. Each region has an enable bit and two sets of read/write/execute permissions, one for privileged requests and one for unprivileged requests. Regions may overlap. A global control word turns the whole unit on or off and selects how overlaps resolve: the highest-index region wins, the permissions of all matching regions are ORed, or they are ANDed. Only a privileged requester can write the region table and the control word. Software can turn the unit off while it rewrites the regions and then turn it back on.

Top module: `mprot_guard`

## Requirements
- R1: A region with size exponent e is hit when the enable bit is set and address bits [AW-1:e] equal the same bits of the base. Base bits below e are ignored. An exponent of AW or more covers the whole address space.
- R2: The access kind is encoded as 0 = read, 1 = write, 2 = fetch and 3 = reserved. A read needs the R permission, a write needs W and a fetch needs X. While the unit is enabled, the reserved kind is always denied.
- R3: Privileged requests (req_priv=1) use the region's privileged permission bits. Unprivileged requests (req_priv=0) use its unprivileged bits. The region attribute word (cfg_op=1) has these fields: bits [5:0] size exponent, bit 6 enable, bits 7/8/9 privileged R/W/X, bits 10/11/12 unprivileged R/W/X.
- R4: While the unit is enabled, an address that hits no enabled region is allowed for a privileged request and denied for an unprivileged one.
- R5: In overlap mode 0, the permissions of the highest-index hit region alone decide the verdict.
- R6: In overlap mode 1, the permissions of all hit regions are ORed together.
- R7: In overlap mode 2, the permissions of all hit regions are ANDed together. Mode 3 behaves as mode 0.
- R8: While the global enable is clear, every access is allowed and no fault is raised. A region whose enable bit is clear never hits.
- R9: One cycle after a request with req_valid=1, resp_valid is 1, resp_allow gives the verdict, and fault is 1 exactly when the access is denied. Without a request in the previous cycle, resp_valid, resp_allow and fault are all 0.
- R10: On a fault while no status is held, the block captures the address, the access kind, the privilege, a hit flag and the highest-index hit region. The capture is visible in the same cycle as the fault. Later faults leave the capture unchanged until it is cleared.
- R11: A configuration write (cfg_we=1) takes effect only when cfg_priv=1; otherwise it is ignored. The operations are: cfg_op=0 writes the base of region cfg_idx; cfg_op=1 writes its attribute word; cfg_op=2 writes the control word (bit 0 enable, bits [2:1] overlap mode); cfg_op=3 clears the status capture.
- R12: A hit region whose permissions for the requester are all clear denies every access kind, including in mode 0 when it lies inside a more permissive lower-index region.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Access request present |
| req_addr | input | AW | Physical address of the access |
| req_type | input | 2 | Access kind: 0 read, 1 write, 2 fetch, 3 reserved |
| req_priv | input | 1 | 1 for a privileged requester |
| resp_valid | output | 1 | Verdict present (one cycle after request) |
| resp_allow | output | 1 | Access allowed |
| fault | output | 1 | One-cycle pulse on a denied access |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_priv | input | 1 | Configuration writer is privileged |
| cfg_op | input | 2 | Write target: base, attribute, control, status clear |
| cfg_idx | input | IW | Region index for base or attribute writes |
| cfg_wdata | input | AW | Write data |
| stat_valid | output | 1 | A fault has been captured |
| stat_addr | output | AW | Captured faulting address |
| stat_type | output | 2 | Captured access kind |
| stat_priv | output | 1 | Captured privilege |
| stat_hit | output | 1 | Captured access hit at least one region |
| stat_region | output | IW | Captured highest-index hit region |

## Verification
The bench places a small high-index region inside a large low-index one. It then checks whether the inner region's narrower rights win in priority mode, add up in union mode and cut down in intersection mode. A design that scanned regions in the wrong direction, or mixed up the OR and AND merges, would turn fetches inside the inner region from denied to allowed. Accesses one byte below and above region edges, and a base written with stray low bits, catch mask errors that would move a fence. Unprivileged writes that try to disable the unit, open a guard region or clear the status must change nothing. A second fault must not overwrite the first capture, and a missing-hit access must report the no-hit flag rather than a stale region index.

// File: rtl/mprot_pkg.sv
package mprot_pkg;
  localparam int SZW = 6;

  typedef enum logic [1:0] {
    ACC_READ  = 2'd0,
    ACC_WRITE = 2'd1,
    ACC_FETCH = 2'd2,
    ACC_RSVD  = 2'd3
  } acc_t;

  typedef enum logic [1:0] {
    OVL_PRIO  = 2'd0,
    OVL_UNION = 2'd1,
    OVL_INTER = 2'd2,
    OVL_SPARE = 2'd3
  } ovl_t;

  typedef enum logic [1:0] {
    CFG_BASE  = 2'd0,
    CFG_ATTR  = 2'd1,
    CFG_CTRL  = 2'd2,
    CFG_CLEAR = 2'd3
  } cfg_op_t;

  typedef struct packed {
    logic x;
    logic w;
    logic r;
  } perm_t;

  typedef struct packed {
    perm_t            usr;
    perm_t            prv;
    logic             en;
    logic [SZW-1:0]   sz;
  } attr_t;

  localparam int ATTR_W = $bits(attr_t);
endpackage

// File: rtl/mprot_regfile.sv
module mprot_regfile
  import mprot_pkg::*;
#(
  parameter int NREG = 8,
  parameter int AW   = 32,
  localparam int IW  = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cfg_we,
  input  logic          cfg_priv,
  input  logic [1:0]    cfg_op,
  input  logic [IW-1:0] cfg_idx,
  input  logic [AW-1:0] cfg_wdata,
  output logic [AW-1:0] base_o [NREG],
  output attr_t         attr_o [NREG],
  output logic          glob_en_o,
  output ovl_t          ovl_mode_o,
  output logic          stat_clr_o
);
  logic wr_ok;
  assign wr_ok      = cfg_we && cfg_priv;
  assign stat_clr_o = wr_ok && (cfg_op == CFG_CLEAR);

  for (genvar g = 0; g < NREG; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (rst) begin
        base_o[g] <= '0;
        attr_o[g] <= '0;
      end else if (wr_ok && (int'(cfg_idx) == g)) begin
        if (cfg_op == CFG_BASE) base_o[g] <= cfg_wdata;
        if (cfg_op == CFG_ATTR) attr_o[g] <= attr_t'(cfg_wdata[ATTR_W-1:0]);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      glob_en_o  <= 1'b0;
      ovl_mode_o <= OVL_PRIO;
    end else if (wr_ok && (cfg_op == CFG_CTRL)) begin
      glob_en_o  <= cfg_wdata[0];
      ovl_mode_o <= ovl_t'(cfg_wdata[2:1]);
    end
  end
endmodule

// File: rtl/mprot_match.sv
module mprot_match
  import mprot_pkg::*;
#(
  parameter int NREG = 8,
  parameter int AW   = 32
) (
  input  logic [AW-1:0]   addr_i,
  input  logic [AW-1:0]   base_i [NREG],
  input  attr_t           attr_i [NREG],
  output logic [NREG-1:0] hit_o
);
  for (genvar g = 0; g < NREG; g++) begin : g_cmp
    logic h;
    always_comb begin
      h = attr_i[g].en;
      for (int j = 0; j < AW; j++) begin
        if ((j >= int'(attr_i[g].sz)) && (addr_i[j] != base_i[g][j])) h = 1'b0;
      end
    end
    assign hit_o[g] = h;
  end
endmodule

// File: rtl/mprot_resolve.sv
module mprot_resolve
  import mprot_pkg::*;
#(
  parameter int NREG = 8,
  localparam int IW  = $clog2(NREG)
) (
  input  logic [NREG-1:0] hit_i,
  input  attr_t           attr_i [NREG],
  input  logic            priv_i,
  input  logic [1:0]      acc_i,
  input  ovl_t            mode_i,
  output logic            allow_o,
  output logic            any_hit_o,
  output logic [IW-1:0]   win_o
);
  logic [2:0] p_win, p_or, p_and, p_eff, p_cur;
  logic       need;

  always_comb begin
    p_win     = '0;
    p_or      = '0;
    p_and     = '1;
    any_hit_o = 1'b0;
    win_o     = '0;
    for (int i = 0; i < NREG; i++) begin
      p_cur = priv_i ? attr_i[i].prv : attr_i[i].usr;
      if (hit_i[i]) begin
        any_hit_o = 1'b1;
        win_o     = IW'(i);
        p_win     = p_cur;
        p_or      = p_or | p_cur;
        p_and     = p_and & p_cur;
      end
    end
    case (mode_i)
      OVL_UNION: p_eff = p_or;
      OVL_INTER: p_eff = p_and;
      default:   p_eff = p_win;
    endcase
    case (acc_i)
      ACC_READ:  need = p_eff[0];
      ACC_WRITE: need = p_eff[1];
      ACC_FETCH: need = p_eff[2];
      default:   need = 1'b0;
    endcase
    allow_o = (acc_i != ACC_RSVD) && (any_hit_o ? need : priv_i);
  end
endmodule

// File: rtl/mprot_guard.sv
module mprot_guard
  import mprot_pkg::*;
#(
  parameter int NREG = 8,
  parameter int AW   = 32,
  localparam int IW  = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req_valid,
  input  logic [AW-1:0] req_addr,
  input  logic [1:0]    req_type,
  input  logic          req_priv,
  output logic          resp_valid,
  output logic          resp_allow,
  output logic          fault,
  input  logic          cfg_we,
  input  logic          cfg_priv,
  input  logic [1:0]    cfg_op,
  input  logic [IW-1:0] cfg_idx,
  input  logic [AW-1:0] cfg_wdata,
  output logic          stat_valid,
  output logic [AW-1:0] stat_addr,
  output logic [1:0]    stat_type,
  output logic          stat_priv,
  output logic          stat_hit,
  output logic [IW-1:0] stat_region
);
  logic [AW-1:0]   base_q [NREG];
  attr_t           attr_q [NREG];
  logic            glob_en;
  ovl_t            ovl_mode;
  logic            stat_clr;
  logic [NREG-1:0] hit;
  logic            rule_ok, any_hit, allow_c;
  logic [IW-1:0]   win;

  mprot_regfile #(.NREG(NREG), .AW(AW)) u_regs (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_priv(cfg_priv),
    .cfg_op(cfg_op), .cfg_idx(cfg_idx), .cfg_wdata(cfg_wdata),
    .base_o(base_q), .attr_o(attr_q), .glob_en_o(glob_en),
    .ovl_mode_o(ovl_mode), .stat_clr_o(stat_clr)
  );

  mprot_match #(.NREG(NREG), .AW(AW)) u_match (
    .addr_i(req_addr), .base_i(base_q), .attr_i(attr_q), .hit_o(hit)
  );

  mprot_resolve #(.NREG(NREG)) u_res (
    .hit_i(hit), .attr_i(attr_q), .priv_i(req_priv), .acc_i(req_type),
    .mode_i(ovl_mode), .allow_o(rule_ok), .any_hit_o(any_hit), .win_o(win)
  );

  assign allow_c = !glob_en || rule_ok;

  always_ff @(posedge clk) begin
    if (rst) begin
      resp_valid  <= 1'b0;
      resp_allow  <= 1'b0;
      fault       <= 1'b0;
      stat_valid  <= 1'b0;
      stat_addr   <= '0;
      stat_type   <= '0;
      stat_priv   <= 1'b0;
      stat_hit    <= 1'b0;
      stat_region <= '0;
    end else begin
      resp_valid <= req_valid;
      resp_allow <= req_valid && allow_c;
      fault      <= req_valid && !allow_c;
      if (req_valid && !allow_c && (!stat_valid || stat_clr)) begin
        stat_valid  <= 1'b1;
        stat_addr   <= req_addr;
        stat_type   <= req_type;
        stat_priv   <= req_priv;
        stat_hit    <= any_hit;
        stat_region <= any_hit ? win : '0;
      end else if (stat_clr) begin
        stat_valid <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/mprot_guard_chk.sv
module mprot_guard_chk #(
  parameter int AW = 32,
  parameter int IW = 3
) (
  input logic          clk,
  input logic          rst,
  input logic          req_valid,
  input logic          resp_valid,
  input logic          resp_allow,
  input logic          fault,
  input logic          cfg_we,
  input logic          cfg_priv,
  input logic          glob_en,
  input logic          stat_clr,
  input logic          stat_valid,
  input logic [AW-1:0] stat_addr,
  input logic [IW-1:0] stat_region
);
  AST_RESP_AFTER_REQ: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> resp_valid); // R9
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> (!resp_valid && !fault && !resp_allow)); // R9
  AST_FAULT_IS_DENY: assert property (@(posedge clk) disable iff (rst)
    fault |-> (resp_valid && !resp_allow)); // R9
  AST_OFF_ALLOWS: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !glob_en) |=> (resp_allow && !fault)); // R8
  AST_STATUS_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (stat_valid && !stat_clr) |=> (stat_valid && $stable(stat_addr) && $stable(stat_region))); // R10
  AST_STATUS_FROM_FAULT: assert property (@(posedge clk) disable iff (rst)
    $rose(stat_valid) |-> fault); // R10
  AST_UNPRIV_CFG_NOP: assert property (@(posedge clk) disable iff (rst)
    (cfg_we && !cfg_priv) |=> $stable(glob_en)); // R11
endmodule

bind mprot_guard mprot_guard_chk #(.AW(AW), .IW(IW)) u_chk (
  .clk(clk), .rst(rst), .req_valid(req_valid), .resp_valid(resp_valid),
  .resp_allow(resp_allow), .fault(fault), .cfg_we(cfg_we), .cfg_priv(cfg_priv),
  .glob_en(glob_en), .stat_clr(stat_clr), .stat_valid(stat_valid),
  .stat_addr(stat_addr), .stat_region(stat_region)
);

// File: tb/mprot_guard_tb_top.sv
`timescale 1ns/1ps
module mprot_guard_tb_top;
  localparam int NREG = 8;
  localparam int AW   = 32;
  localparam int IW   = 3;
  localparam int NV   = 26;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          req_valid = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [1:0]    req_type = '0;
  logic          req_priv = 1'b0;
  logic          resp_valid, resp_allow, fault;
  logic          cfg_we = 1'b0;
  logic          cfg_priv = 1'b0;
  logic [1:0]    cfg_op = '0;
  logic [IW-1:0] cfg_idx = '0;
  logic [AW-1:0] cfg_wdata = '0;
  logic          stat_valid, stat_priv, stat_hit;
  logic [AW-1:0] stat_addr;
  logic [1:0]    stat_type;
  logic [IW-1:0] stat_region;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #2.5 clk = ~clk;

  mprot_guard #(.NREG(NREG), .AW(AW)) dut_i (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_addr(req_addr),
    .req_type(req_type), .req_priv(req_priv), .resp_valid(resp_valid),
    .resp_allow(resp_allow), .fault(fault), .cfg_we(cfg_we), .cfg_priv(cfg_priv),
    .cfg_op(cfg_op), .cfg_idx(cfg_idx), .cfg_wdata(cfg_wdata),
    .stat_valid(stat_valid), .stat_addr(stat_addr), .stat_type(stat_type),
    .stat_priv(stat_priv), .stat_hit(stat_hit), .stat_region(stat_region)
  );

  // vector: {mode[1:0], priv, kind[1:0], expect_allow, addr[31:0]}
  localparam logic [37:0] VEC [NV] = '{
    {2'd0, 1'b0, 2'd0, 1'b1, 32'h0000_0100},  // R2 R3 user read in r0
    {2'd0, 1'b0, 2'd1, 1'b0, 32'h0000_0100},  // R3 user write denied
    {2'd0, 1'b1, 2'd1, 1'b1, 32'h0000_0100},  // R3 priv write allowed
    {2'd0, 1'b0, 2'd2, 1'b1, 32'h0000_0100},  // R2 user fetch in r0
    {2'd0, 1'b0, 2'd0, 1'b1, 32'h0000_4010},  // R5 r1 read
    {2'd0, 1'b0, 2'd2, 1'b0, 32'h0000_4010},  // R5 r1 overrides r0 fetch
    {2'd0, 1'b1, 2'd2, 1'b0, 32'h0000_4010},  // R5 priv fetch in r1
    {2'd0, 1'b1, 2'd1, 1'b1, 32'h0000_4FFF},  // R1 top byte of r1
    {2'd0, 1'b0, 2'd2, 1'b1, 32'h0000_5000},  // R1 just above r1
    {2'd0, 1'b1, 2'd0, 1'b0, 32'h0000_8000},  // R12 guard
    {2'd0, 1'b1, 2'd2, 1'b0, 32'h0000_80FF},  // R12 guard top
    {2'd0, 1'b1, 2'd2, 1'b1, 32'h0000_8100},  // R1 above guard
    {2'd0, 1'b0, 2'd0, 1'b1, 32'h0001_2FFF},  // R1 base low bits ignored
    {2'd0, 1'b0, 2'd1, 1'b0, 32'h0001_2000},  // R2 write needs W
    {2'd0, 1'b1, 2'd0, 1'b1, 32'h0001_1FFF},  // R4 priv no hit
    {2'd0, 1'b0, 2'd0, 1'b0, 32'h0001_1FFF},  // R4 user no hit
    {2'd0, 1'b0, 2'd0, 1'b0, 32'h0002_0010},  // R8 disabled region
    {2'd0, 1'b1, 2'd3, 1'b0, 32'h0000_0100},  // R2 reserved kind
    {2'd1, 1'b0, 2'd2, 1'b1, 32'h0000_4010},  // R6 union fetch
    {2'd1, 1'b0, 2'd1, 1'b0, 32'h0000_4010},  // R6 union write
    {2'd1, 1'b1, 2'd2, 1'b1, 32'h0000_4010},  // R6 union priv fetch
    {2'd2, 1'b0, 2'd0, 1'b1, 32'h0000_4010},  // R7 inter read
    {2'd2, 1'b0, 2'd2, 1'b0, 32'h0000_4010},  // R7 inter fetch
    {2'd2, 1'b1, 2'd1, 1'b1, 32'h0000_4010},  // R7 inter priv write
    {2'd2, 1'b1, 2'd2, 1'b0, 32'h0000_4010},  // R7 inter priv fetch
    {2'd2, 1'b1, 2'd0, 1'b0, 32'h0000_8010}   // R7 inter with guard
  };
  localparam int VREQ [NV] = '{2,3,3,2,5,5,5,1,1,12,12,1,1,2,4,4,8,2,6,6,6,7,7,7,7,7};

  task automatic chk(input string req, input string what, input logic [63:0] act,
                     input logic [63:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic cfg_write(input logic p, input logic [1:0] op, input logic [IW-1:0] idx,
                           input logic [AW-1:0] d);
    cfg_we = 1'b1; cfg_priv = p; cfg_op = op; cfg_idx = idx; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0; cfg_priv = 1'b0;
  endtask

  task automatic do_req(input logic p, input logic [1:0] k, input logic [AW-1:0] a);
    req_valid = 1'b1; req_priv = p; req_type = k; req_addr = a;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic idle();
    @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R9", "reset resp_valid", 64'(resp_valid), 64'd0);
    chk("R9", "reset fault", 64'(fault), 64'd0);
    chk("R10", "reset stat_valid", 64'(stat_valid), 64'd0);

    // region table
    cfg_write(1'b1, 2'd0, 3'd0, 32'h0000_0000);
    cfg_write(1'b1, 2'd1, 3'd0, 32'h0000_17D0);
    cfg_write(1'b1, 2'd0, 3'd1, 32'h0000_4000);
    cfg_write(1'b1, 2'd1, 3'd1, 32'h0000_05CC);
    cfg_write(1'b1, 2'd0, 3'd2, 32'h0000_8000);
    cfg_write(1'b1, 2'd1, 3'd2, 32'h0000_0048);
    cfg_write(1'b1, 2'd0, 3'd3, 32'h0001_2345);
    cfg_write(1'b1, 2'd1, 3'd3, 32'h0000_04CC);
    cfg_write(1'b1, 2'd0, 3'd4, 32'h0002_0000);
    cfg_write(1'b1, 2'd1, 3'd4, 32'h0000_1F8C);

    for (int v = 0; v < NV; v++) begin
      cfg_write(1'b1, 2'd2, 3'd0, {29'd0, VEC[v][37:36], 1'b1});
      do_req(VEC[v][35], VEC[v][34:33], VEC[v][31:0]);
      chk($sformatf("R%0d", VREQ[v]), $sformatf("vec %0d allow", v),
          64'(resp_allow), 64'(VEC[v][32]));
      chk("R9", $sformatf("vec %0d fault", v), 64'(fault), 64'(!VEC[v][32]));
    end

    cfg_write(1'b1, 2'd2, 3'd0, 32'd1);
    cfg_write(1'b1, 2'd3, 3'd0, 32'd0);
    chk("R11", "priv clear", 64'(stat_valid), 64'd0);

    do_req(1'b0, 2'd1, 32'h0000_4020);
    chk("R10", "capture valid", 64'(stat_valid), 64'd1);
    chk("R10", "capture addr", 64'(stat_addr), 64'h4020);
    chk("R10", "capture kind", 64'(stat_type), 64'd1);
    chk("R10", "capture priv", 64'(stat_priv), 64'd0);
    chk("R10", "capture hit", 64'(stat_hit), 64'd1);
    chk("R10", "capture region", 64'(stat_region), 64'd1);
    idle();
    chk("R9", "fault is a pulse", 64'(fault), 64'd0);
    chk("R9", "no req no resp", 64'(resp_valid), 64'd0);
    do_req(1'b1, 2'd0, 32'h0000_8000);
    chk("R10", "second fault raised", 64'(fault), 64'd1);
    chk("R10", "sticky addr", 64'(stat_addr), 64'h4020);
    chk("R10", "sticky region", 64'(stat_region), 64'd1);
    cfg_write(1'b0, 2'd3, 3'd0, 32'd0);
    chk("R11", "unpriv clear ignored", 64'(stat_valid), 64'd1);
    cfg_write(1'b1, 2'd3, 3'd0, 32'd0);
    chk("R11", "priv clear works", 64'(stat_valid), 64'd0);
    do_req(1'b0, 2'd0, 32'h0001_1FFF);
    chk("R10", "no-hit flag", 64'(stat_hit), 64'd0);
    chk("R10", "no-hit addr", 64'(stat_addr), 64'h1_1FFF);

    cfg_write(1'b0, 2'd2, 3'd0, 32'd0);
    do_req(1'b0, 2'd1, 32'h0000_0100);
    chk("R11", "unpriv disable ignored", 64'(resp_allow), 64'd0);
    cfg_write(1'b0, 2'd1, 3'd2, 32'h0000_1FC8);
    do_req(1'b1, 2'd0, 32'h0000_8000);
    chk("R11", "unpriv attr write ignored", 64'(resp_allow), 64'd0);

    cfg_write(1'b1, 2'd2, 3'd0, 32'd0);
    do_req(1'b0, 2'd1, 32'h0000_0100);
    chk("R8", "off allows write", 64'(resp_allow), 64'd1);
    chk("R8", "off no fault", 64'(fault), 64'd0);
    do_req(1'b1, 2'd0, 32'h0000_8000);
    chk("R8", "off allows guard", 64'(resp_allow), 64'd1);

    cfg_write(1'b1, 2'd2, 3'd0, 32'd1);
    cfg_write(1'b1, 2'd0, 3'd5, 32'h0000_0000);
    cfg_write(1'b1, 2'd1, 3'd5, 32'h0000_0460);
    do_req(1'b0, 2'd0, 32'hFFFF_FFF0);
    chk("R1", "full-space region", 64'(resp_allow), 64'd1);
    do_req(1'b0, 2'd2, 32'h0000_0100);
    chk("R5", "r5 overrides r0 fetch", 64'(resp_allow), 64'd0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule